// File: doc/BRIEF.md
# Multi-source reset sequencer

This block turns three reset requests into one ordered reset sequence for an 8-bit CPU. The requests are the external reset pin (active low), a low-voltage flag and a watchdog timeout. Any of them starts phase one. Phase one is a hold whose end depends on the source. An internal source is released once its flag drops, plus an optional number of cycles set by a parameter. The external source is released once the pin has been seen high for a set number of cycles. Phase two is a fixed stabilisation count in CPU clocks, long enough for the oscillator to settle. Phase three reads the reset vector in two consecutive cycles from the top two bytes of the address space.

While the sequence runs, the block holds the CPU in reset. It also pulls the shared reset pin low during the internal hold and during stabilisation. After the two reads it releases the CPU reset and raises a one-cycle done pulse beside the assembled 16-bit vector. A new request restarts the sequence from phase one in any phase. A cause register records which source started the most recent sequence.

Top module: `rstseq_top`

## Requirements
- R1: Three request inputs are recognised, each through a two-flop synchroniser: `ext_rst_n_i` low, `lvd_i` high and `wdg_i` high.
- R2: `pin_pd_o` is high during stabilisation and during phase one of an internal source. It is low during phase one of an external source, during both fetch cycles and in run.
- R3: Phase one ends `LVD_HOLD_CYC`/`WDG_HOLD_CYC` cycles (default 0) after the synchronised internal flag drops. For the external source it ends after the synchronised pin has stayed high for `EXT_HIGH_CYC` cycles (default 16). From the clock edge at which a request input is removed, the first fetch cycle begins after hold + 3 + `STAB_CYC` edges.
- R4: The stabilisation phase lasts exactly `STAB_CYC` clock cycles (default 4096).
- R5: The vector fetch takes two consecutive cycles with `fetch_rd_o` high. The address is 16'hFFFE in the first cycle and 16'hFFFF in the second. `fetch_data_i` is sampled in the cycle it is addressed.
- R6: `vector_o` equals {byte read at FFFEh, byte read at FFFFh}. The first byte is the high byte.
- R7: `done_o` is high for exactly one cycle, the cycle after the second fetch. In that cycle `cpu_rst_o` is low and `vector_o` is valid.
- R8: `cpu_rst_o` rises combinationally with any raw request input. It stays high through every phase and falls only at the clock edge that ends the fetch.
- R9: A request arriving in any phase, the fetch included, returns the block to phase one. The full hold, stabilisation and fetch timing then starts again. The block's own pull-down is never taken as an external request.
- R10: `cause_o` is one-hot, with bit 2 for watchdog, bit 1 for low voltage and bit 0 for external. Simultaneous requests are ranked watchdog, then low voltage, then external. The value holds until a one-cycle `cause_clr_i` sets it to 0, and a request in the same cycle wins over the clear.
- R11: While `rst_n` is low, `cpu_rst_o` is high and `cause_o` is 0. After `rst_n` rises, the block starts in stabilisation, and the first fetch cycle begins `STAB_CYC` edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_n_i | input | 1 | Level read back from the shared reset pin |
| lvd_i | input | 1 | Low-voltage flag, asynchronous |
| wdg_i | input | 1 | Watchdog timeout, asynchronous |
| cause_clr_i | input | 1 | Clears the cause register |
| fetch_data_i | input | 8 | Read data for the vector fetch |
| pin_pd_o | output | 1 | Enable for the pin pull-down driver |
| cpu_rst_o | output | 1 | Reset to the CPU core |
| fetch_rd_o | output | 1 | Vector read strobe |
| fetch_addr_o | output | 16 | Vector read address |
| vector_o | output | 16 | Assembled reset vector |
| done_o | output | 1 | One-cycle handover pulse |
| cause_o | output | 3 | Cause of the latest sequence, one-hot |

## Verification
Most internal faults change a duration, and the ports show that at once. A wrong phase-counter value or a misread hold target moves the first `fetch_rd_o` cycle away from hold + 3 + `STAB_CYC` edges after the request drops. That shows on the first sequence, some four thousand cycles after the request. A swapped fetch state or a stale byte register appears as a wrong `vector_o` in the `done_o` cycle. A pin mask that is too short restarts the sequence right after the fetch, so `done_o` never comes. A wrong priority shows in `cause_o` as soon as one sequence has run with requests that overlap.

// File: rtl/rstseq_pkg.sv
// Shared types of the reset sequencer.
// Assumes a 16-bit CPU address space with the vector at the top two bytes.
package rstseq_pkg;
    localparam int N_SRC = 3;
    localparam logic [15:0] VEC_ADDR_HI = 16'hFFFE;
    localparam logic [15:0] VEC_ADDR_LO = 16'hFFFF;

    typedef enum logic [2:0] {
        PH_RUN, PH_HOLD, PH_STAB, PH_FETCH_HI, PH_FETCH_LO
    } phase_e;

    // The encoding is the bit index in the cause vector, and its order is the priority.
    typedef enum logic [1:0] {
        SRC_EXT = 2'd0, SRC_LVD = 2'd1, SRC_WDG = 2'd2
    } src_e;
endpackage

// File: rtl/rstseq_sync.sv
// Two-flop synchroniser, one chain for each bit.
// Assumes each input bit is an independent level; RST_VAL is the idle level.
module rstseq_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1_q, s2_q;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[g];
                s2_q <= RST_VAL[g];
            end else begin
                s1_q <= d_i[g];
                s2_q <= s1_q;
            end
        end
        assign q_o[g] = s2_q;
    end
endmodule

// File: rtl/rstseq_cause.sv
// Ranks simultaneous requests and keeps the cause register.
// Assumes requests arrive already synchronised; higher index wins.
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             clr_i,
    output logic             any_o,
    output src_e             src_o,
    output logic [N_SRC-1:0] cause_o
);
    logic [N_SRC-1:0] sel;

    // Picks the highest-index active request.
    always_comb begin
        src_o = SRC_EXT;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i]) src_o = src_e'(2'(i));
        end
        sel = '0;
        sel[src_o] = 1'b1;
    end
    assign any_o = |req_i;

    // A new request overwrites the cause, and a clear empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)      cause_o <= '0;
        else if (any_o)  cause_o <= sel;
        else if (clr_i)  cause_o <= '0;
    end

    p_cause_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));
    p_cause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_o && !clr_i) |=> $stable(cause_o));
endmodule

// File: rtl/rstseq_fsm.sv
// Phase controller: source hold, stabilisation count, two-cycle vector fetch.
// Assumes fetch_data_i answers the address in the same cycle, and that
// restart_i is already ranked and synchronised.
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC     = 4096,
    parameter int EXT_HIGH_CYC = 16,
    parameter int LVD_HOLD_CYC = 0,
    parameter int WDG_HOLD_CYC = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart_i,
    input  src_e        restart_src_i,
    input  logic        int_req_i,
    input  logic        ext_high_i,
    input  logic [7:0]  fetch_data_i,
    output phase_e      phase_o,
    output src_e        src_o,
    output logic        fetch_rd_o,
    output logic [15:0] fetch_addr_o,
    output logic [15:0] vector_o,
    output logic        done_o
);
    localparam int HOLD_A   = (EXT_HIGH_CYC > LVD_HOLD_CYC) ? EXT_HIGH_CYC : LVD_HOLD_CYC;
    localparam int HOLD_MAX = (HOLD_A > WDG_HOLD_CYC) ? HOLD_A : WDG_HOLD_CYC;
    localparam int CNT_MAX  = (STAB_CYC > HOLD_MAX) ? STAB_CYC : HOLD_MAX;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    phase_e           ph_q, ph_d;
    src_e             src_q, src_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, target;
    logic [7:0]       vhi_q, vlo_q;
    logic             released;

    // Hold target and release condition of the active source.
    always_comb begin
        case (src_q)
            SRC_EXT: target = CNT_W'(EXT_HIGH_CYC);
            SRC_LVD: target = CNT_W'(LVD_HOLD_CYC);
            default: target = CNT_W'(WDG_HOLD_CYC);
        endcase
        released = (src_q == SRC_EXT) ? ext_high_i : !int_req_i;
    end

    // Next phase: a restart wins, otherwise the phases advance in order.
    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        src_d = src_q;
        if (restart_i) begin
            ph_d  = PH_HOLD;
            cnt_d = '0;
            src_d = restart_src_i;
        end else begin
            case (ph_q)
                PH_HOLD: begin
                    if (!released)            cnt_d = '0;
                    else if (cnt_q >= target) begin ph_d = PH_STAB; cnt_d = '0; end
                    else                      cnt_d = cnt_q + CNT_W'(1);
                end
                PH_STAB: begin
                    if (cnt_q == CNT_W'(STAB_CYC - 1)) begin ph_d = PH_FETCH_HI; cnt_d = '0; end
                    else                               cnt_d = cnt_q + CNT_W'(1);
                end
                PH_FETCH_HI: ph_d = PH_FETCH_LO;
                PH_FETCH_LO: ph_d = PH_RUN;
                default:     ph_d = PH_RUN;
            endcase
        end
    end

    // State, vector bytes and handover pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_STAB;
            cnt_q  <= '0;
            src_q  <= SRC_EXT;
            vhi_q  <= '0;
            vlo_q  <= '0;
            done_o <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            src_q  <= src_d;
            if (ph_q == PH_FETCH_HI) vhi_q <= fetch_data_i;
            if (ph_q == PH_FETCH_LO) vlo_q <= fetch_data_i;
            done_o <= (ph_q == PH_FETCH_LO) && !restart_i;
        end
    end

    assign phase_o      = ph_q;
    assign src_o        = src_q;
    assign fetch_rd_o   = (ph_q == PH_FETCH_HI) || (ph_q == PH_FETCH_LO);
    assign fetch_addr_o = (ph_q == PH_FETCH_LO) ? VEC_ADDR_LO : VEC_ADDR_HI;
    assign vector_o     = {vhi_q, vlo_q};

    // Checker: counts the stabilisation cycles on its own.
    logic [CNT_W:0] chk_stab_q;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_stab_q <= '0;
        else        chk_stab_q <= (ph_q == PH_STAB) ? chk_stab_q + 1'b1 : '0;
    end

    p_stab_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_FETCH_HI && $past(ph_q) == PH_STAB) |-> chk_stab_q == (CNT_W+1)'(STAB_CYC));
    p_fetch_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_FETCH_HI && !restart_i) |=> (fetch_rd_o && fetch_addr_o == VEC_ADDR_LO));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_vec_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> vector_o == {$past(fetch_data_i, 2), $past(fetch_data_i, 1)});
endmodule

// File: rtl/rstseq_top.sv
// Reset sequencer top: synchronises the three requests, masks the block's
// own pin drive, ranks the requests, and runs the phase controller.
// Assumes ext_rst_n_i reads back the shared pin, which pin_pd_o pulls low.
module rstseq_top #(
    parameter int STAB_CYC     = 4096,
    parameter int EXT_HIGH_CYC = 16,
    parameter int LVD_HOLD_CYC = 0,
    parameter int WDG_HOLD_CYC = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_rst_n_i,
    input  logic        lvd_i,
    input  logic        wdg_i,
    input  logic        cause_clr_i,
    input  logic [7:0]  fetch_data_i,
    output logic        pin_pd_o,
    output logic        cpu_rst_o,
    output logic        fetch_rd_o,
    output logic [15:0] fetch_addr_o,
    output logic [15:0] vector_o,
    output logic        done_o,
    output logic [2:0]  cause_o
);
    import rstseq_pkg::*;

    logic [2:0] syn;        // {wdg, lvd, pin level}
    logic       pd_q1, pd_q2, mask, ext_req, any_req;
    src_e       req_src, cur_src;
    phase_e     phase;

    rstseq_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({wdg_i, lvd_i, ext_rst_n_i}), .q_o(syn)
    );

    // The pin stays low for two cycles after the pull-down ends, because of synchroniser lag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q1 <= 1'b1;
            pd_q2 <= 1'b1;
        end else begin
            pd_q1 <= pin_pd_o;
            pd_q2 <= pd_q1;
        end
    end

    assign mask    = pin_pd_o || pd_q1 || pd_q2 || (phase == PH_HOLD);
    assign ext_req = !syn[0] && !mask;

    rstseq_cause u_cause (
        .clk(clk), .rst_n(rst_n), .req_i({syn[2], syn[1], ext_req}),
        .clr_i(cause_clr_i), .any_o(any_req), .src_o(req_src), .cause_o(cause_o)
    );

    rstseq_fsm #(
        .STAB_CYC(STAB_CYC), .EXT_HIGH_CYC(EXT_HIGH_CYC),
        .LVD_HOLD_CYC(LVD_HOLD_CYC), .WDG_HOLD_CYC(WDG_HOLD_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .restart_i(any_req), .restart_src_i(req_src),
        .int_req_i(syn[2] | syn[1]), .ext_high_i(syn[0]), .fetch_data_i(fetch_data_i),
        .phase_o(phase), .src_o(cur_src), .fetch_rd_o(fetch_rd_o),
        .fetch_addr_o(fetch_addr_o), .vector_o(vector_o), .done_o(done_o)
    );

    assign pin_pd_o  = (phase == PH_STAB) || (phase == PH_HOLD && cur_src != SRC_EXT);
    assign cpu_rst_o = !rst_n || (phase != PH_RUN) || lvd_i || wdg_i || !ext_rst_n_i;

    p_rst_in_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rd_o |-> cpu_rst_o);
    p_done_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pin_pd_o);
endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int STAB = 4096;
    localparam int EXTH = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ext_hold = 1'b0, lvd = 1'b0, wdg = 1'b0, clr = 1'b0;
    logic [7:0]  mem_hi = 8'h12, mem_lo = 8'h34, fdata;
    logic        pin, pd, crst, rd, done;
    logic [15:0] addr, vec;
    logic [2:0]  cause;
    int          n_tests = 0, n_fail = 0;

    assign pin   = !(ext_hold || pd);
    assign fdata = (addr == 16'hFFFE) ? mem_hi : (addr == 16'hFFFF) ? mem_lo : 8'hA5;

    rstseq_top u0 (
        .clk(clk), .rst_n(rst_n), .ext_rst_n_i(pin), .lvd_i(lvd), .wdg_i(wdg),
        .cause_clr_i(clr), .fetch_data_i(fdata), .pin_pd_o(pd), .cpu_rst_o(crst),
        .fetch_rd_o(rd), .fetch_addr_o(addr), .vector_o(vec), .done_o(done), .cause_o(cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_lat(input int hold);
        return hold + 3 + STAB;
    endfunction

    function automatic logic [2:0] exp_cause(input logic w, input logic l, input logic e);
        return w ? 3'b100 : l ? 3'b010 : e ? 3'b001 : 3'b000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_fetch(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rd && n < 20000);
    endtask

    // From a request removal to the handover, checked at the ports.
    task automatic finish_seq(input int exp_n);
        int n;
        wait_fetch(n);
        chk("R3 R4 latency to fetch", n, exp_n);
        chk("R5 first address", addr, 16'hFFFE);
        chk("R2 pin released in fetch", pd, 0);
        chk("R8 reset held in fetch", crst, 1);
        @(negedge clk);
        chk("R5 second read", {rd, addr}, {1'b1, 16'hFFFF});
        @(negedge clk);
        chk("R7 done pulse", done, 1);
        chk("R6 vector", vec, {mem_hi, mem_lo});
        chk("R7 reset released", crst, 0);
        @(negedge clk);
        chk("R7 done one cycle", done, 0);
    endtask

    task automatic int_pulse(input logic is_wdg, input int len);
        if (is_wdg) wdg = 1'b1; else lvd = 1'b1;
        #1 chk("R8 async assert", crst, 1);
        repeat (len) @(negedge clk);
        wdg = 1'b0;
        lvd = 1'b0;
    endtask

    task automatic ext_pulse(input int len);
        ext_hold = 1'b1;
        #1 chk("R8 async assert pin", crst, 1);
        repeat (len) @(negedge clk);
        ext_hold = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, src, len;
        void'($urandom(32'd2024));
        // R11: power-on
        repeat (3) @(negedge clk);
        chk("R11 reset cpu", crst, 1);
        chk("R11 reset cause", cause, 0);
        rst_n = 1'b1;
        finish_seq(STAB);

        // R1 R3: low-voltage source, zero extra hold
        mem_hi = 8'hC0; mem_lo = 8'h1D;
        int_pulse(1'b0, 5);
        finish_seq(exp_lat(0));
        chk("R10 cause lvd", cause, 3'b010);

        // R1: watchdog source
        mem_hi = 8'h80; mem_lo = 8'h00;
        int_pulse(1'b1, 1);
        finish_seq(exp_lat(0));
        chk("R10 cause wdg", cause, 3'b100);

        // R1 R2 R3: external pin; no pull-down while the outside holds it
        ext_hold = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 no pull-down in external hold", pd, 0);
        ext_hold = 1'b0;
        finish_seq(exp_lat(EXTH));
        chk("R10 cause ext", cause, 3'b001);

        // R10: clear, then priority with simultaneous requests
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R10 clear", cause, 0);
        wdg = 1'b1; lvd = 1'b1; ext_hold = 1'b1;
        repeat (4) @(negedge clk);
        wdg = 1'b0; lvd = 1'b0; ext_hold = 1'b0;
        finish_seq(exp_lat(0));
        chk("R10 priority wdg", cause, exp_cause(1, 1, 1));
        lvd = 1'b1; ext_hold = 1'b1;
        repeat (4) @(negedge clk);
        lvd = 1'b0; ext_hold = 1'b0;
        finish_seq(exp_lat(0));
        chk("R10 priority lvd", cause, exp_cause(0, 1, 1));

        // R9: restart during stabilisation
        int_pulse(1'b0, 2);
        repeat (100) @(negedge clk);
        chk("R2 pull-down in stabilisation", pd, 1);
        int_pulse(1'b0, 3);
        finish_seq(exp_lat(0));

        // R9: restart during the first fetch cycle
        int_pulse(1'b0, 2);
        repeat (exp_lat(0) - 2) @(negedge clk);
        wdg = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 fetch reached", {rd, addr}, {1'b1, 16'hFFFE});
        @(negedge clk);
        chk("R9 fetch aborted", {rd, pd, done}, 3'b010);
        wdg = 1'b0;
        finish_seq(exp_lat(0));
        chk("R10 cause after abort", cause, 3'b100);

        // Random sources, lengths and vectors
        for (int k = 0; k < 8; k++) begin
            src = $urandom_range(2, 0);
            len = $urandom_range(8, 1);
            mem_hi = 8'($urandom);
            mem_lo = 8'($urandom);
            repeat ($urandom_range(10, 3)) @(negedge clk);
            chk("R2 R8 idle in run", {pd, crst}, 2'b00);
            if (src == 0) ext_pulse(len);
            else int_pulse(src == 2, len);
            finish_seq(exp_lat(src == 0 ? EXTH : 0));
            chk("R10 random cause", cause, exp_cause(src == 2, src == 1, src == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule